// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host-side master for a three-wire serial analog-to-digital converter. It runs from the system clock, derives the serial clock with a programmable divider, drives the active-low convert-start strobe, and shifts in the converter's data line. Each completed conversion is returned as a 12-bit result, widened to 16 bits, on a valid/ready output.

A command port starts single conversions, puts the converter to sleep, and wakes it. Each command is a 2-bit code. A level input selects free-running conversions, paced by a sample-period timer. After reset, the block runs one throw-away conversion before it accepts commands. The converter's power level is tracked and shown on an output.

The controller is built around four states. ST_IDLE holds the strobe high and the serial clock low. ST_SETUP drops the strobe for one divider half-period before any clock. ST_SHIFT runs the serial clock and counts its rising edges. ST_GAP keeps the acquisition gap and the period timer before the controller returns to ST_IDLE.

The transitions are as follows:
- ST_IDLE goes to ST_SETUP when a frame starts. A frame starts when the reset frame is still pending, when free-running mode is on while the converter is awake, or when a command is accepted.
- ST_SETUP goes to ST_SHIFT when the setup count expires.
- ST_SHIFT goes to ST_GAP on the falling serial-clock edge that closes the frame.
- ST_GAP goes to ST_IDLE when both the gap and the period are satisfied.

Top module: `adc_conv_ctrl`

## Requirements
- R1: A frame drops `cnvst`, waits one half-period, and then issues exactly 16 rising `sclk` edges (conversion, wake and reset frames) or 8 (sleep frames). Between frames, `sclk` rests low.
- R2: The bits launched by rising edges 4 through 15 form the result, MSB first. Each bit is captured on the `sclk` falling edge that follows its launching rise. Edges 1–3 and 16 are dropped. `smp_valid` rises on the clock edge that drives the 16th falling `sclk` edge.
- R3: With `bipolar`=1, result bit 11 is copied into bits 15:12 of `smp_data`. With `bipolar`=0, bits 15:12 are zero.
- R4: After reset, `cnvst`=1, `sclk`=0, `smp_valid`=0, `pwr_state`=0 and `cmd_ready`=0. One 16-edge frame runs and reports no sample. Only after that frame does `cmd_ready` rise.
- R5: `cmd_op`=1 (single) starts one conversion frame. `cnvst` returns high on the falling `sclk` edge after the 16th rise.
- R6: While `run_cont`=1 and the converter is awake, frames repeat. In these frames `cnvst` rises on the falling edge after the 14th rise. Successive `cnvst` falls are at least `period` clocks apart. At least 6·`half_div` clocks separate the last `sclk` fall of one frame from the next `cnvst` fall.
- R7: `cmd_op`=2 (sleep) runs an 8-rise frame with `cnvst` raised on the falling edge after the 4th rise. The first sleep frame moves `pwr_state` from 0 (awake) to 1 (light sleep). A second one moves it to 2 (deep sleep).
- R8: `cmd_op`=3 (wake) runs a 16-rise frame with `cnvst` low until the 16th fall. The frame reports no sample and sets `pwr_state` to 0.
- R9: While `pwr_state`≠0 and the block is idle, `cnvst` stays high and `sclk` stays low. A single command is accepted and dropped, and `run_cont` starts nothing.
- R10: While `smp_valid`=1 and `smp_ready`=0, `smp_valid` and `smp_data` hold. A handshake clears `smp_valid`.
- R11: A conversion that completes while the output is stalled keeps the old `smp_data` and sets `overrun`. `overrun` clears on the next handshake.
- R12: Each `sclk` high and low phase lasts `half_div` clocks. A value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | 8 | Clocks per `sclk` phase |
| period | input | 16 | Minimum clocks between free-running frame starts |
| bipolar | input | 1 | Sign-extend the result |
| run_cont | input | 1 | Free-running conversion enable |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 1 single, 2 sleep, 3 wake |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| sclk | output | 1 | Serial clock to the converter |
| cnvst | output | 1 | Convert-start strobe, active low |
| dout | input | 1 | Serial data from the converter |
| smp_valid | output | 1 | Result available |
| smp_ready | input | 1 | Result taken |
| smp_data | output | 16 | Result, zero- or sign-extended |
| overrun | output | 1 | A result was dropped while stalled |
| pwr_state | output | 2 | 0 awake, 1 light sleep, 2 deep sleep |

## Verification
A data bit is due `half_div` clocks after its launching `sclk` rise. The result appears on the same clock edge as the 16th `sclk` fall. The power level and `cmd_ready` update on the frame-closing edge and one idle cycle later. The bench drives inputs and samples outputs on falling clock edges, and every wait for a frame or a sample is a bounded loop on a port. It times `sclk` phases, strobe positions and frame spacing by stamping a cycle counter at the port edges. Each figure is then compared with the count derived from `half_div` and `period`.

// File: rtl/adcc_pkg.sv
`timescale 1ns/1ps
package adcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_GAP
    } ctl_state_e;

    typedef enum logic [1:0] {
        FR_DUMMY,
        FR_CONV,
        FR_SLEEP,
        FR_WAKE
    } frame_kind_e;

    typedef enum logic [1:0] {
        PWR_ON      = 2'd0,
        PWR_PARTIAL = 2'd1,
        PWR_FULL    = 2'd2
    } pwr_level_e;

    localparam logic [1:0] OP_SINGLE = 2'd1;
    localparam logic [1:0] OP_SLEEP  = 2'd2;
    localparam logic [1:0] OP_WAKE   = 2'd3;

endpackage

// File: rtl/adcc_sclk_gen.sv
`timescale 1ns/1ps
// Serial clock generator: toggles every half_div system clocks while run
// is high and flags the cycle before each rising and falling edge.
module adcc_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] lim;
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign lim       = (half_div == '0) ? DIV_W'(1) : half_div;
    assign wrap      = run && (cnt == lim - DIV_W'(1));
    assign rise_tick = wrap && !sclk;
    assign fall_tick = wrap && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/adcc_capture.sv
`timescale 1ns/1ps
// Result shifter and valid/ready output stage with overrun flag.
module adcc_capture #(
    parameter int RES_W = 12,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    input  logic             commit,
    input  logic             bipolar,
    input  logic             smp_ready,
    output logic             smp_valid,
    output logic [OUT_W-1:0] smp_data,
    output logic             overrun
);
    localparam int PAD_W = OUT_W - RES_W;

    logic [RES_W-1:0] shreg;
    logic [OUT_W-1:0] ext;
    logic             taken;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb ext = bipolar ? {{PAD_W{shreg[RES_W-1]}}, shreg}
                                      : {{PAD_W{1'b0}}, shreg};
        end else begin : g_nopad
            always_comb ext = shreg;
        end
    endgenerate

    assign taken = smp_valid && smp_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            smp_valid <= 1'b0;
            smp_data  <= '0;
            overrun   <= 1'b0;
        end else begin
            if (shift_en) begin
                shreg <= {shreg[RES_W-2:0], din};
            end
            if (taken) begin
                overrun <= 1'b0;
            end
            if (commit) begin
                if (smp_valid && !smp_ready) begin
                    overrun <= 1'b1;
                end else begin
                    smp_valid <= 1'b1;
                    smp_data  <= ext;
                end
            end else if (taken) begin
                smp_valid <= 1'b0;
            end
        end
    end

    assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));

    assert_overrun_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> (smp_valid && $stable(smp_data)));

endmodule

// File: rtl/adc_conv_ctrl.sv
`timescale 1ns/1ps
// Host-side sequencer for a three-wire serial converter.
module adc_conv_ctrl
    import adcc_pkg::*;
#(
    parameter int DIV_W          = 8,
    parameter int PER_W          = 16,
    parameter int RES_W          = 12,
    parameter int OUT_W          = 16,
    parameter int LEAD_ZEROS     = 3,
    parameter int FRAME_RISES    = 16,
    parameter int SLEEP_RISES    = 8,
    parameter int SLEEP_RAISE_AT = 4,
    parameter int CONT_RAISE_AT  = 14,
    parameter int ACQ_PERIODS    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic [PER_W-1:0] period,
    input  logic             bipolar,
    input  logic             run_cont,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    output logic             cmd_ready,
    output logic             sclk,
    output logic             cnvst,
    input  logic             dout,
    output logic             smp_valid,
    input  logic             smp_ready,
    output logic [OUT_W-1:0] smp_data,
    output logic             overrun,
    output logic [1:0]       pwr_state
);
    localparam int CNT_W     = $clog2(FRAME_RISES + 1);
    localparam int GAP_W     = DIV_W + $clog2(2 * ACQ_PERIODS + 1);
    localparam int FIRST_BIT = LEAD_ZEROS + 1;
    localparam int LAST_BIT  = LEAD_ZEROS + RES_W;

    ctl_state_e       state, state_n;
    frame_kind_e      kind, kind_n;
    pwr_level_e       pwr;
    logic             need_dummy;
    logic [CNT_W-1:0] rcnt;
    logic [CNT_W-1:0] frame_len;
    logic [GAP_W-1:0] tcnt;
    logic [GAP_W-1:0] gap_min;
    logic [GAP_W-1:0] setup_lim;
    logic [DIV_W-1:0] lim;
    logic [PER_W-1:0] per_cnt;
    logic             cnvst_q;
    logic             sclk_run;
    logic             rise_tick;
    logic             fall_tick;
    logic             frame_end;
    logic             shift_en;
    logic             commit;
    logic             cmd_take;
    logic             conv_req;
    logic             period_met;
    logic             start;

    assign lim        = (half_div == '0) ? DIV_W'(1) : half_div;
    assign gap_min    = GAP_W'(lim) * GAP_W'(2 * ACQ_PERIODS);
    assign setup_lim  = GAP_W'(lim);
    assign frame_len  = (kind == FR_SLEEP) ? CNT_W'(SLEEP_RISES) : CNT_W'(FRAME_RISES);
    assign frame_end  = (state == ST_SHIFT) && fall_tick && (rcnt == frame_len);
    assign conv_req   = run_cont && (pwr == PWR_ON);
    assign period_met = !run_cont || (per_cnt >= period);
    assign start      = (state == ST_IDLE) && (state_n == ST_SETUP);

    // Output decode
    always_comb begin
        cmd_ready = (state == ST_IDLE) && !need_dummy && !conv_req;
        cmd_take  = cmd_valid && cmd_ready;
        sclk_run  = (state == ST_SHIFT);
        shift_en  = sclk_run && fall_tick && (kind == FR_CONV) &&
                    (rcnt >= CNT_W'(FIRST_BIT)) && (rcnt <= CNT_W'(LAST_BIT));
        commit    = frame_end && (kind == FR_CONV);
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        kind_n  = kind;
        unique case (state)
            ST_IDLE: begin
                if (need_dummy) begin
                    state_n = ST_SETUP;
                    kind_n  = FR_DUMMY;
                end else if (conv_req) begin
                    state_n = ST_SETUP;
                    kind_n  = FR_CONV;
                end else if (cmd_take) begin
                    unique case (cmd_op)
                        OP_SINGLE: begin
                            if (pwr == PWR_ON) begin
                                state_n = ST_SETUP;
                                kind_n  = FR_CONV;
                            end
                        end
                        OP_SLEEP: begin
                            state_n = ST_SETUP;
                            kind_n  = FR_SLEEP;
                        end
                        OP_WAKE: begin
                            state_n = ST_SETUP;
                            kind_n  = FR_WAKE;
                        end
                        default: ;
                    endcase
                end
            end
            ST_SETUP: begin
                if (tcnt >= setup_lim - GAP_W'(1)) state_n = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (frame_end) state_n = ST_GAP;
            end
            ST_GAP: begin
                if ((tcnt >= gap_min - GAP_W'(1)) && period_met) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            kind  <= FR_DUMMY;
            tcnt  <= '0;
        end else begin
            state <= state_n;
            kind  <= kind_n;
            if (state_n != state) begin
                tcnt <= '0;
            end else if (tcnt != '1) begin
                tcnt <= tcnt + GAP_W'(1);
            end
        end
    end

    // Strobe, edge counter, period timer and power level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnvst_q    <= 1'b1;
            rcnt       <= '0;
            per_cnt    <= '0;
            pwr        <= PWR_ON;
            need_dummy <= 1'b1;
        end else if (start) begin
            cnvst_q <= 1'b0;
            rcnt    <= '0;
            per_cnt <= '0;
        end else begin
            if (per_cnt != '1) per_cnt <= per_cnt + PER_W'(1);
            if (rise_tick) rcnt <= rcnt + CNT_W'(1);
            if (sclk_run && fall_tick) begin
                if (rcnt == frame_len) cnvst_q <= 1'b1;
                if ((kind == FR_SLEEP) && (rcnt == CNT_W'(SLEEP_RAISE_AT))) cnvst_q <= 1'b1;
                if ((kind == FR_CONV) && run_cont && (rcnt == CNT_W'(CONT_RAISE_AT))) cnvst_q <= 1'b1;
            end
            if (frame_end) begin
                unique case (kind)
                    FR_DUMMY: need_dummy <= 1'b0;
                    FR_SLEEP: pwr <= (pwr == PWR_ON) ? PWR_PARTIAL : PWR_FULL;
                    FR_WAKE:  pwr <= PWR_ON;
                    default:  ;
                endcase
            end
        end
    end

    assign cnvst     = cnvst_q;
    assign pwr_state = pwr;

    adcc_sclk_gen #(
        .DIV_W(DIV_W)
    ) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sclk_run),
        .half_div (half_div),
        .sclk     (sclk),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick)
    );

    adcc_capture #(
        .RES_W(RES_W),
        .OUT_W(OUT_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (dout),
        .commit   (commit),
        .bipolar  (bipolar),
        .smp_ready(smp_ready),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .overrun  (overrun)
    );

    assert_rise_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (rcnt <= frame_len));

    assert_no_sample_before_dummy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> !need_dummy);

    assert_fall_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnvst) |-> ($past(state) == ST_IDLE));

    assert_sleep_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == FR_SLEEP) && (state == ST_SHIFT) && (rcnt > CNT_W'(SLEEP_RAISE_AT))) |-> cnvst);

    assert_down_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr != PWR_ON) && (state == ST_IDLE)) |-> (cnvst && !sclk));

endmodule

// File: tb/adc_conv_ctrl_tb.sv
`timescale 1ns/1ps
module adc_conv_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  half_div = 8'd4;
    logic [15:0] period = 16'd0;
    logic        bipolar = 1'b0;
    logic        run_cont = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_ready;
    logic        sclk;
    logic        cnvst;
    logic        dout = 1'b0;
    logic        smp_valid;
    logic        smp_ready = 1'b0;
    logic [15:0] smp_data;
    logic        overrun;
    logic [1:0]  pwr_state;

    always #2.5 clk = ~clk;

    adc_conv_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .half_div(half_div), .period(period),
        .bipolar(bipolar), .run_cont(run_cont), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_ready(cmd_ready), .sclk(sclk), .cnvst(cnvst),
        .dout(dout), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_data(smp_data), .overrun(overrun), .pwr_state(pwr_state)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Converter model and port-edge timestamps
    logic [11:0] adc_code = 12'h000;
    int frame_id = 0, seen_id = 0, cnt = 0, rise_tot = 0, rise_at_up = 0;
    int fall_t = 0, fall_prev = 0, last_sfall = 0, rise_t = 0, hi_w = 0, acq_gap = 0;
    int got = 0;
    logic [15:0] last_data = 16'h0;

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge cnvst) begin
        frame_id  = frame_id + 1;
        fall_prev = fall_t;
        fall_t    = cyc;
        acq_gap   = cyc - last_sfall;
    end

    always @(posedge sclk) begin
        if (seen_id != frame_id) begin
            seen_id = frame_id;
            cnt = 1;
        end else begin
            cnt = cnt + 1;
        end
        rise_tot = rise_tot + 1;
        rise_t   = cyc;
        if (cnt >= 4 && cnt <= 15) dout <= adc_code[15 - cnt];
        else dout <= 1'b0;
    end

    always @(negedge sclk) begin
        last_sfall = cyc;
        hi_w       = cyc - rise_t;
    end

    always @(posedge cnvst) rise_at_up = (seen_id == frame_id) ? cnt : 0;

    always @(posedge clk) begin
        if (rst_n && smp_valid && smp_ready) begin
            got = got + 1;
            last_data = smp_data;
        end
    end

    function automatic int fr_rises();
        return (seen_id == frame_id) ? cnt : 0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_true(input string req, input string what, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op);
        bit ok = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        for (int i = 0; i < 5000; i++) begin
            if (cmd_ready) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        chk_true("R5", "command accepted", ok, 0, 1);
    endtask

    task automatic wait_ready();
        bit ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (cmd_ready) begin
                ok = 1'b1;
                break;
            end
        end
        chk_true("R1", "frame completed", ok, 0, 1);
    endtask

    task automatic wait_valid();
        bit ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (smp_valid) begin
                ok = 1'b1;
                break;
            end
        end
        chk_true("R2", "sample arrived", ok, 0, 1);
    endtask

    task automatic ack();
        @(negedge clk);
        smp_ready = 1'b1;
        @(negedge clk);
        smp_ready = 1'b0;
    endtask

    // [28] bipolar, [27:16] converter code, [15:0] expected result
    localparam logic [28:0] VEC [6] = '{
        {1'b0, 12'h000, 16'h0000},
        {1'b0, 12'hFFF, 16'h0FFF},
        {1'b1, 12'h800, 16'hF800},
        {1'b1, 12'h7FF, 16'h07FF},
        {1'b0, 12'hA5C, 16'h0A5C},
        {1'b1, 12'h9C3, 16'hF9C3}
    };

    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int f0;
        int r0;
        int g0;

        // Reset state (R4)
        repeat (3) @(negedge clk);
        chk("R4", "cnvst in reset", int'(cnvst), 1);
        chk("R4", "sclk in reset", int'(sclk), 0);
        chk("R4", "smp_valid in reset", int'(smp_valid), 0);
        chk("R4", "cmd_ready in reset", int'(cmd_ready), 0);
        chk("R4", "pwr_state in reset", int'(pwr_state), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4", "cmd_ready while reset frame pending", int'(cmd_ready), 0);
        wait_ready();
        chk("R4", "reset frame count", frame_id, 1);
        chk("R4", "reset frame rises", fr_rises(), 16);
        chk("R4", "no sample from reset frame", int'(smp_valid), 0);

        // Vector table: single conversions (R1 R2 R3 R5 R10 R12)
        foreach (VEC[i]) begin
            bipolar  = VEC[i][28];
            adc_code = VEC[i][27:16];
            issue(2'd1);
            wait_valid();
            chk("R2", "result data", int'(smp_data), int'(VEC[i][15:0]));
            chk("R1", "rises at sample", fr_rises(), 16);
            chk("R2", "sclk low at sample", int'(sclk), 0);
            wait_ready();
            chk("R5", "cnvst raised after rise", rise_at_up, 16);
            chk("R12", "sclk high phase", hi_w, 4);
            ack();
            chk("R10", "valid cleared by handshake", int'(smp_valid), 0);
        end
        bipolar = 1'b0;

        // Stall and overrun (R10 R11)
        adc_code = 12'h123;
        issue(2'd1);
        wait_valid();
        repeat (40) @(negedge clk);
        chk("R10", "valid held while stalled", int'(smp_valid), 1);
        chk("R10", "data held while stalled", int'(smp_data), 16'h0123);
        adc_code = 12'h456;
        issue(2'd1);
        wait_ready();
        chk("R11", "overrun set", int'(overrun), 1);
        chk("R11", "old data kept", int'(smp_data), 16'h0123);
        ack();
        chk("R11", "overrun cleared", int'(overrun), 0);
        chk("R11", "valid cleared", int'(smp_valid), 0);

        // Free-running conversions (R6)
        adc_code  = 12'h3C5;
        period    = 16'd400;
        smp_ready = 1'b1;
        g0 = got;
        run_cont = 1'b1;
        for (int i = 0; i < 5000 && got < g0 + 3; i++) @(negedge clk);
        chk("R6", "free-running samples", got - g0, 3);
        chk("R6", "cnvst rise after 14th edge", rise_at_up, 14);
        chk_true("R6", "start spacing", (fall_t - fall_prev) >= 400 && (fall_t - fall_prev) <= 404,
                 fall_t - fall_prev, 400);
        chk("R2", "free-running data", int'(last_data), 16'h03C5);
        period = 16'd0;
        g0 = got;
        for (int i = 0; i < 5000 && got < g0 + 3; i++) @(negedge clk);
        chk_true("R6", "acquisition gap", acq_gap >= 24, acq_gap, 24);
        chk_true("R6", "short period spacing", (fall_t - fall_prev) < 400, fall_t - fall_prev, 400);
        run_cont = 1'b0;
        wait_ready();
        smp_ready = 1'b0;
        repeat (2) @(negedge clk);

        // Sleep frames (R7)
        issue(2'd2);
        wait_ready();
        chk("R7", "light sleep level", int'(pwr_state), 1);
        chk("R7", "sleep frame rises", fr_rises(), 8);
        chk("R7", "sleep cnvst rise", rise_at_up, 4);
        issue(2'd2);
        wait_ready();
        chk("R7", "deep sleep level", int'(pwr_state), 2);

        // Quiet while asleep (R9)
        f0 = frame_id;
        r0 = rise_tot;
        issue(2'd1);
        repeat (300) @(negedge clk);
        chk("R9", "no frame from single", frame_id, f0);
        chk("R9", "no sclk edges", rise_tot, r0);
        chk("R9", "cnvst high", int'(cnvst), 1);
        chk("R9", "no sample", int'(smp_valid), 0);
        run_cont = 1'b1;
        repeat (300) @(negedge clk);
        chk("R9", "no frame from run_cont", frame_id, f0);
        chk("R9", "ready while asleep", int'(cmd_ready), 1);
        run_cont = 1'b0;

        // Wake (R8)
        g0 = got;
        issue(2'd3);
        wait_ready();
        chk("R8", "awake level", int'(pwr_state), 0);
        chk("R8", "wake frame rises", fr_rises(), 16);
        chk("R8", "wake cnvst rise", rise_at_up, 16);
        chk("R8", "no sample from wake", int'(smp_valid), 0);
        bipolar  = 1'b1;
        adc_code = 12'hC3A;
        issue(2'd1);
        wait_valid();
        chk("R8", "conversion after wake", int'(smp_data), 16'hFC3A);
        ack();
        wait_ready();
        bipolar = 1'b0;

        // Divider corners (R12)
        half_div = 8'd0;
        adc_code = 12'h5A5;
        issue(2'd1);
        wait_valid();
        chk("R12", "zero divider phase", hi_w, 1);
        chk("R2", "data at fastest clock", int'(smp_data), 16'h05A5);
        ack();
        wait_ready();
        half_div = 8'd2;
        adc_code = 12'h0F1;
        issue(2'd1);
        wait_valid();
        chk("R12", "divider 2 phase", hi_w, 2);
        chk("R2", "data at divider 2", int'(smp_data), 16'h00F1);
        ack();
        wait_ready();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule